// File: doc/BRIEF.md
# Non-Volatile Latch Backup Sequencer

This controller drives the control lines of a four-transistor storage latch that carries a complementary pair of magnetic junctions. It has four modes of operation. Ordinary writes pass straight through to the latch. Retention parks the latch so that leakage alone holds its value. A backup sequence copies the latch bit into the junction pair by thermally assisted switching. A restore sequence reloads the latch from the junctions. The transistor circuit, the junction physics and the circuit that generates the field all sit outside the block. The block only sequences the word lines, the bit-line drive mode, the field enable and the field polarity.

Backup writes the two junctions one after the other. For each junction there is a precharge phase, a heating phase and a field phase. The heating phase waits for an external indication that the junction has reached its blocking temperature, and a programmable limit bounds that wait. Restore is a precharge phase followed by a release phase in which the latch resolves on its own. After reset the block runs one restore before it accepts any other request. During a backup or restore sequence the block is busy and new requests are ignored. A one-cycle done pulse marks the end of each sequence.

Top module: `nvl_backup_seq`

## Requirements
- R1: While reset is held and afterwards, the block runs a restore before it accepts any request. It shows busy=1 with both word lines high during reset and for PRE_CYC-1 further cycles. It then shows REL_CYC release cycles and the done cycle. A request made in that time has no effect.
- R2: When the block is idle and mode_req is 2'b00 (retain), both word lines are low. bl_force is 0, which means both bit lines are tied to supply. bl_val, fld_en and fld_pol are 0.
- R3: When the block is idle and mode_req is 2'b01 (write), both word lines are high and bl_force is 1. In the same cycle bl_val equals data_in, and the complement bit line carries its inverse.
- R4: When the block is idle, a 2'b11 (restore) request starts the sequence in the next cycle. The sequence is PRE_CYC cycles with both word lines high and bl_force=0, then REL_CYC cycles with every line low.
- R5: An idle 2'b10 (backup) request starts junction 1 in the next cycle. Junction 1 gets PRE_CYC cycles with only wl2 high, then heating with both word lines high. Junction 2 precharges with only wl1 high, then heats with both word lines high. Junction 2 starts only after junction 1 has finished.
- R6: fld_en is high only while busy is high and both word lines are high.
- R7: The heating phase lasts up to and including the first cycle in which temp_ok is sampled high. fld_en then stays high for FIELD_CYC cycles.
- R8: The field polarity for junction 2 is the inverse of the polarity for junction 1.
- R9: If temp_ok stays low for the first heat_limit cycles of a heating phase, the block aborts after that many cycles and goes straight to the done cycle. From then on err=1 until the next accepted backup or restore. If temp_ok arrives in exactly cycle heat_limit, the backup succeeds.
- R10: While busy=1, mode_req is ignored. done is high for exactly one cycle, the first idle cycle after a sequence, and busy is 0 in that cycle.
- R11: At the end of each junction write, fld_en falls one cycle before the word lines fall. Between the two junction writes there is exactly one cycle with every line low.
- R12: Junction 1's field polarity equals latch_q as sampled in the cycle of the backup request. Changes to latch_q after that cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 2 | 00 retain, 01 write, 10 backup, 11 restore |
| data_in | input | 1 | Bit to write in write mode |
| latch_q | input | 1 | Sensed latch value, captured at backup request |
| temp_ok | input | 1 | Heated junction has reached blocking temperature |
| heat_limit | input | TO_W | Maximum heating cycles before abort |
| wl1 | output | 1 | Word line 1 |
| wl2 | output | 1 | Word line 2 |
| bl_force | output | 1 | 1: bit lines driven with bl_val and complement; 0: both at supply |
| bl_val | output | 1 | Value on the true bit line when forced |
| fld_en | output | 1 | Magnetic field enable |
| fld_pol | output | 1 | Magnetic field polarity |
| busy | output | 1 | Backup or restore sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Last backup aborted on heating timeout |

## Verification
In idle, the line outputs follow mode_req and data_in within the same cycle. A backup or restore request causes no visible change in its own cycle, and the sequence appears from the following cycle. The done pulse and any new err value appear in the cycle after the last sequence step. Every phase lasts exactly its parameter length, except heating, which lasts until the cycle in which temp_ok is first seen, or until heat_limit cycles. For each stimulus, the bench builds a queue with one expected output vector per cycle, counted from the request cycle. Inputs change on the falling edge and outputs are compared two time units later, so each queue entry lines up with exactly one clock period.

// File: rtl/nvl_pkg.sv
package nvl_pkg;

    typedef enum logic [1:0] {
        REQ_RETAIN  = 2'b00,
        REQ_WRITE   = 2'b01,
        REQ_BACKUP  = 2'b10,
        REQ_RESTORE = 2'b11
    } req_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RPRE  = 3'd1,
        ST_RREL  = 3'd2,
        ST_BPRE  = 3'd3,
        ST_BHEAT = 3'd4,
        ST_BFLD  = 3'd5,
        ST_BCOOL = 3'd6,
        ST_BGAP  = 3'd7
    } st_e;

    typedef struct packed {
        logic wl1;
        logic wl2;
        logic bl_force;
        logic bl_val;
        logic fld_en;
        logic fld_pol;
    } drive_t;

    localparam drive_t DRV_OFF = '0;

    // Width of the shared phase counter: wide enough for every fixed
    // phase length and for the heating limit, plus one guard bit.
    function automatic int step_cnt_width(int a, int b, int c, int w);
        int m;
        int bits;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        bits = $clog2(m + 1);
        if (w > bits) bits = w;
        return bits + 1;
    endfunction

    // Line levels for a given controller state.
    function automatic drive_t line_drive(st_e st, logic jsel, logic pol,
                                          logic [1:0] req, logic din);
        drive_t d;
        d = DRV_OFF;
        case (st)
            ST_IDLE: begin
                if (req == REQ_WRITE) begin
                    d.wl1      = 1'b1;
                    d.wl2      = 1'b1;
                    d.bl_force = 1'b1;
                    d.bl_val   = din;
                end
            end
            ST_RPRE: begin
                d.wl1 = 1'b1;
                d.wl2 = 1'b1;
            end
            ST_BPRE: begin
                // junction 1 precharges through wl2, junction 2 through wl1
                d.wl1 = jsel;
                d.wl2 = ~jsel;
            end
            ST_BHEAT, ST_BCOOL: begin
                d.wl1 = 1'b1;
                d.wl2 = 1'b1;
            end
            ST_BFLD: begin
                d.wl1     = 1'b1;
                d.wl2     = 1'b1;
                d.fld_en  = 1'b1;
                d.fld_pol = pol;
            end
            default: d = DRV_OFF;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/nvl_step_timer.sv
module nvl_step_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/nvl_seq_ctrl.sv
module nvl_seq_ctrl
    import nvl_pkg::*;
#(
    parameter int PRE_CYC   = 3,
    parameter int REL_CYC   = 2,
    parameter int FIELD_CYC = 4,
    parameter int TO_W      = 8,
    parameter int CW        = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      req,
    input  logic            latch_q,
    input  logic            temp_ok,
    input  logic [TO_W-1:0] heat_limit,
    input  logic [CW-1:0]   cnt,
    output st_e             st,
    output logic            jsel,
    output logic            pol,
    output logic            tclr,
    output logic            done,
    output logic            err
);
    localparam logic [CW-1:0] PRE_LAST = CW'(PRE_CYC - 1);
    localparam logic [CW-1:0] REL_LAST = CW'(REL_CYC - 1);
    localparam logic [CW-1:0] FLD_LAST = CW'(FIELD_CYC - 1);

    st_e  st_n;
    logic jsel_n, cap, cap_n, done_n, err_n;
    logic [CW-1:0] cnt_nx;
    logic          heat_expired;

    assign cnt_nx       = cnt + 1'b1;
    assign heat_expired = (cnt_nx >= CW'(heat_limit));

    always_comb begin
        st_n   = st;
        jsel_n = jsel;
        cap_n  = cap;
        done_n = 1'b0;
        err_n  = err;
        case (st)
            ST_IDLE: begin
                if (req == REQ_BACKUP) begin
                    st_n   = ST_BPRE;
                    jsel_n = 1'b0;
                    cap_n  = latch_q;
                    err_n  = 1'b0;
                end else if (req == REQ_RESTORE) begin
                    st_n  = ST_RPRE;
                    err_n = 1'b0;
                end
            end
            ST_RPRE:  if (cnt == PRE_LAST) st_n = ST_RREL;
            ST_RREL: begin
                if (cnt == REL_LAST) begin
                    st_n   = ST_IDLE;
                    done_n = 1'b1;
                end
            end
            ST_BPRE:  if (cnt == PRE_LAST) st_n = ST_BHEAT;
            ST_BHEAT: begin
                if (temp_ok) begin
                    st_n = ST_BFLD;
                end else if (heat_expired) begin
                    st_n   = ST_IDLE;
                    done_n = 1'b1;
                    err_n  = 1'b1;
                end
            end
            ST_BFLD:  if (cnt == FLD_LAST) st_n = ST_BCOOL;
            ST_BCOOL: begin
                if (!jsel) begin
                    st_n = ST_BGAP;
                end else begin
                    st_n   = ST_IDLE;
                    done_n = 1'b1;
                end
            end
            ST_BGAP: begin
                st_n   = ST_BPRE;
                jsel_n = 1'b1;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    assign tclr = (st_n != st);
    assign pol  = cap ^ jsel;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_RPRE;
            jsel <= 1'b0;
            cap  <= 1'b0;
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            st   <= st_n;
            jsel <= jsel_n;
            cap  <= cap_n;
            done <= done_n;
            err  <= err_n;
        end
    end
endmodule

// File: rtl/nvl_line_drive.sv
module nvl_line_drive
    import nvl_pkg::*;
(
    input  st_e        st,
    input  logic       jsel,
    input  logic       pol,
    input  logic [1:0] req,
    input  logic       din,
    output drive_t     drv
);
    assign drv = line_drive(st, jsel, pol, req, din);
endmodule

// File: rtl/nvl_backup_seq.sv
module nvl_backup_seq
    import nvl_pkg::*;
#(
    parameter int PRE_CYC   = 3,
    parameter int REL_CYC   = 2,
    parameter int FIELD_CYC = 4,
    parameter int TO_W      = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      mode_req,
    input  logic            data_in,
    input  logic            latch_q,
    input  logic            temp_ok,
    input  logic [TO_W-1:0] heat_limit,
    output logic            wl1,
    output logic            wl2,
    output logic            bl_force,
    output logic            bl_val,
    output logic            fld_en,
    output logic            fld_pol,
    output logic            busy,
    output logic            done,
    output logic            err
);
    localparam int CW = step_cnt_width(PRE_CYC, REL_CYC, FIELD_CYC, TO_W);

    logic [CW-1:0] cnt;
    logic          tclr, jsel, pol;
    st_e           st;
    drive_t        drv;

    nvl_step_timer #(.CW(CW)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (tclr),
        .cnt (cnt)
    );

    nvl_seq_ctrl #(
        .PRE_CYC  (PRE_CYC),
        .REL_CYC  (REL_CYC),
        .FIELD_CYC(FIELD_CYC),
        .TO_W     (TO_W),
        .CW       (CW)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req       (mode_req),
        .latch_q   (latch_q),
        .temp_ok   (temp_ok),
        .heat_limit(heat_limit),
        .cnt       (cnt),
        .st        (st),
        .jsel      (jsel),
        .pol       (pol),
        .tclr      (tclr),
        .done      (done),
        .err       (err)
    );

    nvl_line_drive u_drive (
        .st  (st),
        .jsel(jsel),
        .pol (pol),
        .req (mode_req),
        .din (data_in),
        .drv (drv)
    );

    assign wl1      = drv.wl1;
    assign wl2      = drv.wl2;
    assign bl_force = drv.bl_force;
    assign bl_val   = drv.bl_val;
    assign fld_en   = drv.fld_en;
    assign fld_pol  = drv.fld_pol;
    assign busy     = (st != ST_IDLE);
endmodule

// File: rtl/nvl_backup_seq_chk.sv
module nvl_backup_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_req,
    input logic       data_in,
    input logic       temp_ok,
    input logic       wl1,
    input logic       wl2,
    input logic       bl_force,
    input logic       bl_val,
    input logic       fld_en,
    input logic       busy,
    input logic       done
);
    // R2
    retain_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && mode_req == 2'b00) |-> (!wl1 && !wl2 && !bl_force && !fld_en));

    // R3
    write_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && mode_req == 2'b01) |-> (wl1 && wl2 && bl_force && bl_val == data_in));

    // R6
    field_gate_chk: assert property (@(posedge clk) disable iff (rst)
        fld_en |-> (wl1 && wl2 && busy));

    // R7
    field_after_temp_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fld_en) |-> $past(temp_ok));

    // R11
    field_first_off_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fld_en) |-> (wl1 && wl2));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind nvl_backup_seq nvl_backup_seq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode_req(mode_req),
    .data_in (data_in),
    .temp_ok (temp_ok),
    .wl1     (wl1),
    .wl2     (wl2),
    .bl_force(bl_force),
    .bl_val  (bl_val),
    .fld_en  (fld_en),
    .busy    (busy),
    .done    (done)
);

// File: tb/nvl_backup_seq_test.sv
module nvl_backup_seq_test;
    localparam int PRE = 3;
    localparam int REL = 2;
    localparam int FLD = 4;
    localparam int TOW = 8;

    localparam logic [1:0] M_RET = 2'b00;
    localparam logic [1:0] M_WR  = 2'b01;
    localparam logic [1:0] M_BK  = 2'b10;
    localparam logic [1:0] M_RS  = 2'b11;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst;
    logic [1:0]     mode_req;
    logic           data_in, latch_q, temp_ok;
    logic [TOW-1:0] heat_limit;
    logic wl1, wl2, bl_force, bl_val, fld_en, fld_pol, busy, done, err;

    nvl_backup_seq #(.PRE_CYC(PRE), .REL_CYC(REL), .FIELD_CYC(FLD), .TO_W(TOW)) uut (
        .clk(clk), .rst(rst), .mode_req(mode_req), .data_in(data_in),
        .latch_q(latch_q), .temp_ok(temp_ok), .heat_limit(heat_limit),
        .wl1(wl1), .wl2(wl2), .bl_force(bl_force), .bl_val(bl_val),
        .fld_en(fld_en), .fld_pol(fld_pol), .busy(busy), .done(done), .err(err)
    );

    int   n_chk = 0;
    int   n_err = 0;
    int   heat_delay = 1000;
    int   hcnt = 0;
    logic err_exp = 1'b0;
    bit   finished = 1'b0;

    logic [8:0] exp_q[$];
    string      tag_q[$];

    // {wl1,wl2,bl_force,bl_val,fld_en,fld_pol,busy,done,err}
    function automatic logic [8:0] v(bit w1, bit w2, bit bf, bit bv, bit fe,
                                     bit fp, bit bz, bit dn, bit er);
        return {w1, w2, bf, bv, fe, fp, bz, dn, er};
    endfunction

    task automatic push(input logic [8:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    // External heater model: temp_ok rises after heat_delay heating cycles
    always @(negedge clk) begin
        if (wl1 && wl2 && !fld_en) hcnt = hcnt + 1;
        else hcnt = 0;
        temp_ok = (hcnt > 0) && (hcnt >= heat_delay);
    end

    // Per-cycle comparison against the expected queue
    initial begin
        forever begin
            logic [8:0] act, expv;
            string      tg;
            @(negedge clk);
            #2;
            act = {wl1, wl2, bl_force, bl_val, fld_en, fld_pol, busy, done, err};
            if (exp_q.size() > 0) begin
                expv = exp_q.pop_front();
                tg   = tag_q.pop_front();
            end else if (mode_req == M_WR) begin
                expv = v(1, 1, 1, data_in, 0, 0, 0, 0, err_exp);
                tg   = "R3 write idle";
            end else begin
                expv = v(0, 0, 0, 0, 0, 0, 0, 0, err_exp);
                tg   = "R2 retention idle";
            end
            n_chk++;
            if (act !== expv) begin
                n_err++;
                $display("FAIL %s at %0t: actual=%b expected=%b", tg, $time, act, expv);
            end
        end
    end

    task automatic do_idle(input logic [1:0] m, input bit d, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mode_req = m;
            data_in  = d;
        end
    endtask

    task automatic do_restore(input logic [1:0] ign, input string tg);
        int len;
        @(negedge clk);
        mode_req = M_RS;
        push(v(0, 0, 0, 0, 0, 0, 0, 0, err_exp), {tg, " R10 request"});
        for (int i = 0; i < PRE; i++) push(v(1, 1, 0, 0, 0, 0, 1, 0, 0), {tg, " R4 precharge"});
        for (int i = 0; i < REL; i++) push(v(0, 0, 0, 0, 0, 0, 1, 0, 0), {tg, " R4 release"});
        err_exp = 1'b0;
        push(v(0, 0, 0, 0, 0, 0, 0, 1, 0), {tg, " R10 done"});
        len = PRE + REL;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            mode_req = ign;
        end
        @(negedge clk);
        mode_req = M_RET;
    endtask

    task automatic do_backup(input bit q, input int k, input int lim,
                             input logic [1:0] ign, input string tg);
        bit ok;
        int len;
        ok = (k <= lim);
        @(negedge clk);
        mode_req   = M_BK;
        latch_q    = q;
        heat_limit = TOW'(lim);
        heat_delay = k;
        push(v(0, 0, 0, 0, 0, 0, 0, 0, err_exp), {tg, " R10 request"});
        len = 0;
        for (int j = 0; j < 2; j++) begin
            bit p;
            p = q ^ j[0];
            for (int i = 0; i < PRE; i++) begin
                if (j == 0) push(v(0, 1, 0, 0, 0, 0, 1, 0, 0), {tg, " R5 precharge wl2"});
                else        push(v(1, 0, 0, 0, 0, 0, 1, 0, 0), {tg, " R5 precharge wl1"});
                len++;
            end
            if (!ok) begin
                for (int i = 0; i < lim; i++) begin
                    push(v(1, 1, 0, 0, 0, 0, 1, 0, 0), {tg, " R9 heat before abort"});
                    len++;
                end
                break;
            end
            for (int i = 0; i < k; i++) begin
                push(v(1, 1, 0, 0, 0, 0, 1, 0, 0), {tg, " R7 heat"});
                len++;
            end
            for (int i = 0; i < FLD; i++) begin
                push(v(1, 1, 0, 0, 1, p, 1, 0, 0), {tg, " R8 R12 R6 field"});
                len++;
            end
            push(v(1, 1, 0, 0, 0, 0, 1, 0, 0), {tg, " R11 field off first"});
            len++;
            if (j == 0) begin
                push(v(0, 0, 0, 0, 0, 0, 1, 0, 0), {tg, " R11 gap"});
                len++;
            end
        end
        err_exp = !ok;
        push(v(0, 0, 0, 0, 0, 0, 0, 1, !ok), {tg, " R9 R10 done"});
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            mode_req = ign;     // R10: ignored while busy
            latch_q  = ~q;      // R12: no effect after capture
        end
        @(negedge clk);
        mode_req = M_RET;
    endtask

    // Watchdog
    initial begin
        #2000000;
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst        = 1'b1;
        mode_req   = M_RET;
        data_in    = 1'b0;
        latch_q    = 1'b0;
        heat_limit = TOW'(10);
        temp_ok    = 1'b0;
        // R1: reset state and power-up restore
        for (int i = 0; i < 3; i++) push(v(1, 1, 0, 0, 0, 0, 1, 0, 0), "R1 reset state");
        for (int i = 0; i < PRE - 1; i++) push(v(1, 1, 0, 0, 0, 0, 1, 0, 0), "R1 power-up precharge");
        for (int i = 0; i < REL; i++) push(v(0, 0, 0, 0, 0, 0, 1, 0, 0), "R1 power-up release");
        push(v(0, 0, 0, 0, 0, 0, 0, 1, 0), "R1 power-up done");
        repeat (3) @(negedge clk);
        rst      = 1'b0;
        mode_req = M_BK;            // R1: must be ignored during power-up restore
        repeat (PRE - 1 + REL) @(negedge clk);
        @(negedge clk);
        mode_req = M_RET;

        do_idle(M_RET, 1'b1, 2);    // R2
        do_idle(M_WR, 1'b1, 2);     // R3
        do_idle(M_WR, 1'b0, 2);     // R3

        do_backup(1'b1, 2, 10, M_WR, "backup q1");
        do_backup(1'b0, 1, 10, M_RS, "backup q0");
        do_backup(1'b1, 3, 3, M_RET, "R9 boundary");
        do_idle(M_WR, 1'b1, 1);
        do_backup(1'b0, 5, 3, M_WR, "R9 timeout");
        do_idle(M_WR, 1'b1, 3);     // R9: err stays set
        do_idle(M_RET, 1'b0, 2);
        do_restore(M_BK, "restore");
        do_idle(M_RET, 1'b0, 2);
        do_backup(1'b1, 1, 1, M_RET, "R9 limit one");
        do_idle(M_RET, 1'b0, 3);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule